// File: doc/BRIEF.md
# ADC Channel Conversion Sequencer

This block drives a successive-approximation converter through a simple request/done handshake. It picks one of eight analog channels, issues conversion requests in the order the selected sequencing mode calls for, and captures each returned sample into a result register together with the channel it came from. Every captured result raises an interrupt flag, which software clears by writing a one.

A run begins on a software start pulse, or on a rising edge of an external trigger line when that source is enabled. The external line is typically the output of a pulse generator, so it is resynchronised before use. There are four modes:

- **Single**: one conversion of the start channel.
- **Scan**: one pass over a channel range.
- **Continuous**: repeats the range until halted.
- **Stop**: converts one channel per trigger and waits in between.

Results are delivered at either 10-bit or 8-bit precision.

Top module: `adc_seq`

## Requirements
- R1: After reset, busy and conv_start are low, irq_flag is low, and res_data and res_ch are zero.
- R2: A run begins on a one-cycle sw_start pulse. It also begins on a rising edge of ext_trig, but only while cfg_ext_en is 1. With cfg_ext_en at 0, edges on ext_trig start nothing.
- R3: With cfg_mode = 2'b00 (single), exactly one conversion of cfg_first_ch is made. busy then returns low.
- R4: A trigger that arrives while a conversion is being requested or awaited is ignored. No extra conversion follows it.
- R5: With cfg_mode = 2'b01 (scan), channels are converted in ascending order from cfg_first_ch to cfg_last_ch, wrapping from 7 to 0, once. busy then returns low. Equal first and last channels give one conversion.
- R6: With cfg_mode = 2'b10 (continuous), the range is converted over and over. A sw_halt pulse lets the conversion in progress finish and deliver its result, and then the block goes idle.
- R7: With cfg_mode = 2'b11 (stop), each trigger converts the next channel of the range and the block then pauses with busy high. After the last channel the range restarts at the first. A sw_halt pulse during the pause returns the block to idle.
- R8: On each accepted conv_done, res_ch takes the converted channel one cycle later. With cfg_res8 = 0, res_data takes the full 10-bit sample.
- R9: With cfg_res8 = 1, res_data is {2'b00, sample[9:2]}.
- R10: irq_flag is set by every captured result. It is cleared by irq_clr = 1, and a simultaneous capture wins over the clear.
- R11: conv_start is a one-cycle pulse, and conv_ch stays stable while the block waits for conv_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Sequencing mode: 00 single, 01 scan, 10 continuous, 11 stop |
| cfg_first_ch | input | 3 | First channel of the range (the only channel in single mode) |
| cfg_last_ch | input | 3 | Last channel of the range |
| cfg_res8 | input | 1 | 1 selects 8-bit results |
| cfg_ext_en | input | 1 | Enables the external trigger |
| sw_start | input | 1 | Software start pulse |
| sw_halt | input | 1 | Software halt pulse |
| ext_trig | input | 1 | Asynchronous external trigger, rising edge active |
| conv_start | output | 1 | Conversion request pulse to the converter |
| conv_ch | output | 3 | Channel being converted |
| conv_done | input | 1 | Converter completion pulse |
| conv_data | input | 10 | Converter sample, valid with conv_done |
| res_data | output | 10 | Result register |
| res_ch | output | 3 | Channel of the result |
| irq_flag | output | 1 | Result-ready interrupt flag |
| irq_clr | input | 1 | Write-one clear of irq_flag |
| busy | output | 1 | High from trigger acceptance until the run ends |

## Verification
The hardest situation to reach is a halt that lands while a continuous run is between request and completion. The halt has to be held pending until the sample arrives, and the result must still be delivered. The stimulus counts conversion requests at the ports and fires sw_halt in the cycle after a chosen request. The converter stub holds its reply for several cycles, so the halt is certain to fall inside the wait. Randomised single and scan runs with random ranges, including wrapping ones, and random result widths then cover the channel ordering.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_SCAN   = 2'b01,
    MODE_CONT   = 2'b10,
    MODE_STOP   = 2'b11
  } seq_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_PAUSE
  } seq_state_e;
endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_en,
  input  logic ext_in,
  input  logic sw_pulse,
  output logic trig
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= ext_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign trig = sw_pulse | (ext_en & s2_q & ~s3_q);
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CHW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     mode,
  input  logic [CHW-1:0] first_ch,
  input  logic [CHW-1:0] last_ch,
  input  logic           trig,
  input  logic           halt,
  input  logic           done,
  output logic           busy,
  output logic           issue,
  output logic           waiting,
  output logic           accept,
  output logic [CHW-1:0] ch
);
  seq_state_e     state_q, state_d;
  logic [CHW-1:0] ch_q, ch_d;
  logic           halt_q, halt_d;
  logic           at_last, stop_now;
  logic [CHW-1:0] ch_inc, ch_nxt;
  seq_mode_e      mode_e;

  assign mode_e   = seq_mode_e'(mode);
  assign at_last  = (ch_q == last_ch);
  assign ch_inc   = (ch_q == CHW'(NCH - 1)) ? '0 : ch_q + 1'b1;
  assign ch_nxt   = at_last ? first_ch : ch_inc;
  assign stop_now = halt_q | halt;

  always_comb begin
    state_d = state_q;
    ch_d    = ch_q;
    halt_d  = halt_q;
    case (state_q)
      ST_IDLE: begin
        halt_d = 1'b0;
        if (trig) begin
          state_d = ST_ISSUE;
          ch_d    = first_ch;
        end
      end
      ST_ISSUE: begin
        state_d = ST_WAIT;
        if (halt) halt_d = 1'b1;
      end
      ST_WAIT: begin
        if (halt) halt_d = 1'b1;
        if (done) begin
          case (mode_e)
            MODE_SINGLE: state_d = ST_IDLE;
            MODE_SCAN: begin
              if (at_last) state_d = ST_IDLE;
              else begin
                state_d = ST_ISSUE;
                ch_d    = ch_inc;
              end
            end
            MODE_CONT: begin
              state_d = stop_now ? ST_IDLE : ST_ISSUE;
              ch_d    = ch_nxt;
            end
            default: begin
              state_d = stop_now ? ST_IDLE : ST_PAUSE;
              ch_d    = ch_nxt;
            end
          endcase
        end
      end
      default: begin
        if (halt)      state_d = ST_IDLE;
        else if (trig) state_d = ST_ISSUE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
      halt_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ch_q    <= ch_d;
      halt_q  <= halt_d;
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign issue   = (state_q == ST_ISSUE);
  assign waiting = (state_q == ST_WAIT);
  assign accept  = waiting & done;
  assign ch      = ch_q;
endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
  parameter int W      = 10,
  parameter int NARROW = 8,
  parameter int CHW    = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           capture,
  input  logic           res8,
  input  logic [W-1:0]   sample,
  input  logic [CHW-1:0] ch,
  input  logic           irq_clr,
  output logic [W-1:0]   res_data,
  output logic [CHW-1:0] res_ch,
  output logic           irq_flag
);
  logic [W-1:0] shaped;
  logic         irq_d;

  assign shaped = res8 ? {{(W-NARROW){1'b0}}, sample[W-1 -: NARROW]} : sample;
  assign irq_d  = capture ? 1'b1 : (irq_clr ? 1'b0 : irq_flag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_data <= '0;
      res_ch   <= '0;
    end else if (capture) begin
      res_data <= shaped;
      res_ch   <= ch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_flag <= 1'b0;
    else        irq_flag <= irq_d;
  end
endmodule

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int NCH    = 8,
  parameter int W      = 10,
  parameter int NARROW = 8,
  localparam int CHW   = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     cfg_mode,
  input  logic [CHW-1:0] cfg_first_ch,
  input  logic [CHW-1:0] cfg_last_ch,
  input  logic           cfg_res8,
  input  logic           cfg_ext_en,
  input  logic           sw_start,
  input  logic           sw_halt,
  input  logic           ext_trig,
  output logic           conv_start,
  output logic [CHW-1:0] conv_ch,
  input  logic           conv_done,
  input  logic [W-1:0]   conv_data,
  output logic [W-1:0]   res_data,
  output logic [CHW-1:0] res_ch,
  output logic           irq_flag,
  input  logic           irq_clr,
  output logic           busy
);
  logic trig, waiting, accept;

  adc_trig_sync u_trig (
    .clk(clk), .rst_n(rst_n), .ext_en(cfg_ext_en), .ext_in(ext_trig),
    .sw_pulse(sw_start), .trig(trig)
  );

  adc_seq_fsm #(.NCH(NCH)) u_fsm (
    .clk(clk), .rst_n(rst_n), .mode(cfg_mode), .first_ch(cfg_first_ch),
    .last_ch(cfg_last_ch), .trig(trig), .halt(sw_halt), .done(conv_done),
    .busy(busy), .issue(conv_start), .waiting(waiting), .accept(accept),
    .ch(conv_ch)
  );

  adc_result_reg #(.W(W), .NARROW(NARROW), .CHW(CHW)) u_res (
    .clk(clk), .rst_n(rst_n), .capture(accept), .res8(cfg_res8),
    .sample(conv_data), .ch(conv_ch), .irq_clr(irq_clr),
    .res_data(res_data), .res_ch(res_ch), .irq_flag(irq_flag)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int W      = 10,
  parameter int NARROW = 8,
  parameter int CHW    = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic [1:0]     cfg_mode,
  input logic           cfg_res8,
  input logic           conv_start,
  input logic [CHW-1:0] conv_ch,
  input logic           conv_done,
  input logic [W-1:0]   conv_data,
  input logic           waiting,
  input logic           accept,
  input logic [W-1:0]   res_data,
  input logic [CHW-1:0] res_ch,
  input logic           irq_flag,
  input logic           irq_clr,
  input logic           busy
);
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R11
  AST_CH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !conv_done) |=> $stable(conv_ch)); // R11
  AST_SINGLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cfg_mode == 2'b00) |=> !busy); // R3
  AST_RES_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cfg_res8) |=> (res_data == $past(conv_data))); // R8
  AST_RES_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cfg_res8) |=> (res_data == {{(W-NARROW){1'b0}}, $past(conv_data[W-1 -: NARROW])})); // R9
  AST_RES_CH: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (res_ch == $past(conv_ch))); // R8
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> irq_flag); // R10
  AST_IRQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !accept) |=> !irq_flag); // R10
endmodule

bind adc_seq adc_seq_chk #(.W(W), .NARROW(NARROW), .CHW(CHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_res8(cfg_res8),
  .conv_start(conv_start), .conv_ch(conv_ch), .conv_done(conv_done),
  .conv_data(conv_data), .waiting(waiting), .accept(accept),
  .res_data(res_data), .res_ch(res_ch), .irq_flag(irq_flag),
  .irq_clr(irq_clr), .busy(busy)
);

// File: tb/tb_adc_seq.sv
module tb_adc_seq;
  localparam int W = 10;
  localparam int LAT = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n;
  logic [1:0] cfg_mode;
  logic [2:0] cfg_first_ch, cfg_last_ch;
  logic       cfg_res8, cfg_ext_en, sw_start, sw_halt, ext_trig, irq_clr;
  logic       conv_start, conv_done, irq_flag, busy;
  logic [2:0] conv_ch, res_ch;
  logic [W-1:0] conv_data, res_data;

  adc_seq dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_first_ch(cfg_first_ch),
    .cfg_last_ch(cfg_last_ch), .cfg_res8(cfg_res8), .cfg_ext_en(cfg_ext_en),
    .sw_start(sw_start), .sw_halt(sw_halt), .ext_trig(ext_trig),
    .conv_start(conv_start), .conv_ch(conv_ch), .conv_done(conv_done),
    .conv_data(conv_data), .res_data(res_data), .res_ch(res_ch),
    .irq_flag(irq_flag), .irq_clr(irq_clr), .busy(busy)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter stub
  int           cnt;
  logic [W-1:0] pend;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_done <= 1'b0;
      conv_data <= '0;
      cnt       <= 0;
      pend      <= '0;
    end else begin
      conv_done <= 1'b0;
      if (cnt != 0) begin
        cnt <= cnt - 1;
        if (cnt == 1) begin
          conv_done <= 1'b1;
          conv_data <= pend;
        end
      end
      if (conv_start) begin
        cnt  <= LAT;
        pend <= W'($urandom);
      end
    end
  end

  // monitor
  int           nstart = 0;
  logic [2:0]   st_ch [0:255];
  bit           chk_pend = 0;
  logic [W-1:0] last_d;
  logic [2:0]   last_c;

  function automatic logic [W-1:0] shape(input logic [W-1:0] d, input logic r8);
    return r8 ? {2'b00, d[9:2]} : d;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (chk_pend) begin
        chk(res_data == shape(last_d, cfg_res8), cfg_res8 ? "R9 data" : "R8 data",
            int'(res_data), int'(shape(last_d, cfg_res8)));
        chk(res_ch == last_c, "R8 channel", int'(res_ch), int'(last_c));
        chk(irq_flag == 1'b1, "R10 set", int'(irq_flag), 1);
        chk_pend = 0;
      end
      if (conv_done) begin
        chk_pend = 1;
        last_d   = conv_data;
        last_c   = conv_ch;
      end
      if (conv_start) begin
        st_ch[nstart[7:0]] = conv_ch;
        nstart++;
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk) sw_start = 1'b1;
    @(negedge clk) sw_start = 1'b0;
  endtask

  task automatic pulse_halt();
    @(negedge clk) sw_halt = 1'b1;
    @(negedge clk) sw_halt = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    for (int k = 0; k < 2000 && busy; k++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_range(input int s, input int e, input int base, input string req);
    int len;
    len = ((e - s) & 7) + 1;
    chk(nstart - base == len, {req, " count"}, nstart - base, len);
    for (int i = 0; i < len && i < nstart - base; i++)
      chk(st_ch[(base + i) & 255] == 3'((s + i) & 7), {req, " order"},
          int'(st_ch[(base + i) & 255]), (s + i) & 7);
  endtask

  task automatic setup(input logic [1:0] m, input int s, input int e, input logic r8);
    @(negedge clk);
    cfg_mode = m; cfg_first_ch = 3'(s); cfg_last_ch = 3'(e); cfg_res8 = r8;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int base, seed;
    logic [1:0] rm;
    int rs, re;
    seed = $urandom(32'h5A17);
    rst_n = 1'b0; cfg_mode = 2'b00; cfg_first_ch = 3'd0; cfg_last_ch = 3'd0;
    cfg_res8 = 1'b0; cfg_ext_en = 1'b0; sw_start = 1'b0; sw_halt = 1'b0;
    ext_trig = 1'b0; irq_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(conv_start == 1'b0, "R1 conv_start", int'(conv_start), 0);
    chk(irq_flag == 1'b0, "R1 irq", int'(irq_flag), 0);
    chk(res_data == '0 && res_ch == '0, "R1 result", int'(res_data), 0);

    // R3 single
    setup(2'b00, 5, 1, 1'b0);
    base = nstart;
    pulse_start();
    wait_idle();
    chk_range(5, 5, base, "R3");
    chk(busy == 1'b0, "R3 idle", int'(busy), 0);

    // R10 clear
    @(negedge clk) irq_clr = 1'b1;
    @(negedge clk) irq_clr = 1'b0;
    chk(irq_flag == 1'b0, "R10 clear", int'(irq_flag), 0);

    // R4 trigger during conversion ignored
    base = nstart;
    pulse_start();
    repeat (2) @(negedge clk);
    pulse_start();
    wait_idle();
    chk(nstart - base == 1, "R4 ignored trigger", nstart - base, 1);

    // R5 scan, plain, wrapping and full
    setup(2'b01, 2, 5, 1'b0); base = nstart; pulse_start(); wait_idle(); chk_range(2, 5, base, "R5");
    setup(2'b01, 6, 1, 1'b1); base = nstart; pulse_start(); wait_idle(); chk_range(6, 1, base, "R5 wrap");
    setup(2'b01, 0, 7, 1'b0); base = nstart; pulse_start(); wait_idle(); chk_range(0, 7, base, "R5 full");
    chk(busy == 1'b0, "R5 idle", int'(busy), 0);

    // R6 continuous with halt mid-conversion
    setup(2'b10, 3, 4, 1'b0);
    base = nstart;
    pulse_start();
    for (int k = 0; k < 500 && nstart - base < 5; k++) @(negedge clk);
    pulse_halt();
    wait_idle();
    chk(nstart - base == 5, "R6 count", nstart - base, 5);
    for (int i = 0; i < 5; i++)
      chk(st_ch[(base + i) & 255] == ((i % 2 == 0) ? 3'd3 : 3'd4), "R6 order",
          int'(st_ch[(base + i) & 255]), (i % 2 == 0) ? 3 : 4);
    chk(res_ch == 3'd3, "R6 last result delivered", int'(res_ch), 3);

    // R7 stop mode
    setup(2'b11, 1, 2, 1'b0);
    base = nstart;
    pulse_start(); repeat (20) @(negedge clk);
    chk(busy == 1'b1, "R7 paused busy", int'(busy), 1);
    chk(nstart - base == 1, "R7 one per trigger", nstart - base, 1);
    pulse_start(); repeat (20) @(negedge clk);
    pulse_start(); repeat (20) @(negedge clk);
    chk(nstart - base == 3, "R7 count", nstart - base, 3);
    chk(st_ch[(base + 1) & 255] == 3'd2, "R7 second", int'(st_ch[(base + 1) & 255]), 2);
    chk(st_ch[(base + 2) & 255] == 3'd1, "R7 wrap", int'(st_ch[(base + 2) & 255]), 1);
    pulse_halt();
    repeat (2) @(negedge clk);
    chk(busy == 1'b0, "R7 halt", int'(busy), 0);

    // R2 external trigger enabled and disabled
    setup(2'b00, 6, 6, 1'b1);
    cfg_ext_en = 1'b1;
    base = nstart;
    @(negedge clk) ext_trig = 1'b1;
    repeat (3) @(negedge clk);
    wait_idle();
    chk(nstart - base == 1, "R2 ext start", nstart - base, 1);
    chk(res_ch == 3'd6, "R2 ext channel", int'(res_ch), 6);
    ext_trig = 1'b0;
    repeat (4) @(negedge clk);
    cfg_ext_en = 1'b0;
    base = nstart;
    @(negedge clk) ext_trig = 1'b1;
    repeat (10) @(negedge clk);
    chk(nstart - base == 0 && busy == 1'b0, "R2 ext disabled", nstart - base, 0);
    ext_trig = 1'b0;

    // random single/scan runs
    for (int it = 0; it < 30; it++) begin
      rm = 2'($urandom_range(0, 1));
      rs = $urandom_range(0, 7);
      re = $urandom_range(0, 7);
      setup(rm, rs, re, 1'($urandom_range(0, 1)));
      base = nstart;
      pulse_start();
      wait_idle();
      chk_range(rs, (rm == 2'b00) ? rs : re, base, (rm == 2'b00) ? "R3 random" : "R5 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule